// File: doc/BRIEF.md
# Memory-Mapped Character Terminal Controller

This block sits on a processor's load/store port and presents a character terminal as four word-wide device registers at fixed addresses in the top 64 KB of the address space. One side receives characters from a keyboard-like source. The other side sends characters to a display-like sink. Each side has a status/control word and a data word.

Software can poll the Ready flags. It can also set a per-side interrupt-enable bit and wait for the level-sensitive interrupt line. Ready flags change as a side effect of data-register accesses: a load of the received character consumes it, and a store of an outgoing character marks the transmitter busy until the sink reports completion.

The bus port completes in a single cycle. A load's data appears combinationally in the same cycle as the request, and every register update, including the side effects, takes place at the next rising clock edge.

Top module: `mmio_terminal`

## Requirements
- R1: After reset the receive Ready flag is 0, the transmit Ready flag is 1, both interrupt-enable bits are 0, the overrun bit is 0 and the interrupt line is low.
- R2: A cycle with `kb_valid` high stores `kb_char` and sets receive Ready at the next edge. A load from 0xFFFF0004 returns the stored character in bits 7:0 with bits 31:8 zero.
- R3: A load from 0xFFFF0004 clears receive Ready at the next edge, unless a new character arrives in the same cycle. No other access clears it.
- R4: A store to 0xFFFF000C while transmit Ready is 1 does three things at the next edge: it places bits 7:0 of the write data on `disp_char`, raises `disp_valid` and clears transmit Ready. A store there while transmit Ready is 0 is ignored.
- R5: `disp_done` high while a character is pending sets transmit Ready and drops `disp_valid` at the next edge. `disp_done` has no effect while nothing is pending.
- R6: Bit 1 of each control word is its interrupt enable. `irq` is high exactly when some side has both its enable and its Ready flag at 1.
- R7: Bit 2 of the receive control word (0xFFFF0000) is a sticky overrun flag. It sets when a character arrives while receive Ready is 1 and that cycle is not a load from 0xFFFF0004. The new character replaces the old one and Ready stays 1. Only reset clears the flag.
- R8: A store to a control word (receive at 0xFFFF0000, transmit at 0xFFFF0008) changes only its bit 1. Bit 0 of each control word is Ready. Unused bits read as zero.
- R9: Accesses to any other address, including 0xFFFF0010 and addresses outside the window, change no state. `bus_rdata` is zero whenever the cycle is not a load from one of the three readable words (0xFFFF0000, 0xFFFF0004 and 0xFFFF0008).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address of the word accessed |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, same cycle |
| kb_valid | input | 1 | Incoming character strobe |
| kb_char | input | 8 | Incoming character |
| disp_char | output | 8 | Outgoing character |
| disp_valid | output | 1 | Outgoing character pending |
| disp_done | input | 1 | Sink has finished the pending character |
| irq | output | 1 | Level interrupt request |

## Verification
Two pairs of events can land in the same cycle. On the receive side, a character can arrive in the cycle that software loads the receive data word. On the transmit side, the sink can report completion in the cycle that software stores another character. The bench forces both collisions in directed steps, and the random phase raises `kb_valid` and `disp_done` often enough to hit them many more times. A bench reference model then checks the outcome. A load that collides with an arrival must return the old character and leave Ready set without flagging overrun. A store that collides with completion must be dropped while Ready returns to 1.

// File: rtl/term_pkg.sv
package term_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_CTRL,
    SEL_RX_DATA,
    SEL_TX_CTRL,
    SEL_TX_DATA
  } term_sel_e;

  typedef struct packed {
    term_sel_e sel;
    logic      rd;
    logic      wr;
  } term_acc_t;

  // word offsets inside the window; software depends on them
  localparam int unsigned OFS_RX_CTRL = 0;
  localparam int unsigned OFS_RX_DATA = 4;
  localparam int unsigned OFS_TX_CTRL = 8;
  localparam int unsigned OFS_TX_DATA = 12;

  // control word bit positions
  localparam int unsigned BIT_READY   = 0;
  localparam int unsigned BIT_IE      = 1;
  localparam int unsigned BIT_OVERRUN = 2;

endpackage

// File: rtl/term_rst_sync.sv
module term_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/term_addr_dec.sv
module term_addr_dec
  import term_pkg::*;
#(
  parameter int unsigned          ADDR_W = 32,
  parameter logic [ADDR_W-1:0]    BASE   = 32'hFFFF_0000
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output term_acc_t         acc
);
  localparam logic [ADDR_W-1:0] A_RXC = BASE + ADDR_W'(OFS_RX_CTRL);
  localparam logic [ADDR_W-1:0] A_RXD = BASE + ADDR_W'(OFS_RX_DATA);
  localparam logic [ADDR_W-1:0] A_TXC = BASE + ADDR_W'(OFS_TX_CTRL);
  localparam logic [ADDR_W-1:0] A_TXD = BASE + ADDR_W'(OFS_TX_DATA);

  term_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (req) begin
      if      (addr == A_RXC) sel = SEL_RX_CTRL;
      else if (addr == A_RXD) sel = SEL_RX_DATA;
      else if (addr == A_TXC) sel = SEL_TX_CTRL;
      else if (addr == A_TXD) sel = SEL_TX_DATA;
    end
  end

  always_comb begin
    acc.sel = sel;
    acc.rd  = (sel != SEL_NONE) && !we;
    acc.wr  = (sel != SEL_NONE) && we;
  end
endmodule

// File: rtl/term_rx_side.sv
module term_rx_side #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_valid,
  input  logic [CHAR_W-1:0] dev_char,
  input  logic              data_rd,
  input  logic              ctrl_wr,
  input  logic              ie_in,
  output logic              ready,
  output logic              ie,
  output logic              overrun,
  output logic [CHAR_W-1:0] data
);
  logic              ready_d, ie_d, ovr_d;
  logic [CHAR_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    ready_d = ready;
    ovr_d   = overrun;
    data_en = dev_valid;
    data_d  = dev_char;
    ie_d    = ctrl_wr ? ie_in : ie;
    if (dev_valid) begin
      ready_d = 1'b1;
      if (ready && !data_rd) ovr_d = 1'b1;
    end else if (data_rd) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready   <= 1'b0;
      ie      <= 1'b0;
      overrun <= 1'b0;
    end else begin
      ready   <= ready_d;
      ie      <= ie_d;
      overrun <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data <= '0;
    else if (data_en) data <= data_d;
  end
endmodule

// File: rtl/term_tx_side.sv
module term_tx_side #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              ctrl_wr,
  input  logic              ie_in,
  input  logic              dev_done,
  output logic              ready,
  output logic              ie,
  output logic [CHAR_W-1:0] char_q
);
  logic ready_d, ie_d, char_en;

  always_comb begin
    ready_d = ready;
    char_en = 1'b0;
    ie_d    = ctrl_wr ? ie_in : ie;
    if (!ready) begin
      if (dev_done) ready_d = 1'b1;
    end else if (data_wr) begin
      ready_d = 1'b0;
      char_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b1;
      ie    <= 1'b0;
    end else begin
      ready <= ready_d;
      ie    <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       char_q <= '0;
    else if (char_en) char_q <= wr_char;
  end
endmodule

// File: rtl/mmio_terminal.sv
module mmio_terminal
  import term_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter int unsigned       CHAR_W     = 8,
  parameter int unsigned       RST_STAGES = 2,
  parameter logic [ADDR_W-1:0] BASE       = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_char,
  output logic [CHAR_W-1:0] disp_char,
  output logic              disp_valid,
  input  logic              disp_done,
  output logic              irq
);
  term_acc_t         acc;
  logic              rst_n_sync;
  logic              rx_data_rd, rx_ctrl_wr, tx_ctrl_wr, tx_data_wr;
  logic              rx_rdy, rx_ie, rx_ovr, tx_rdy, tx_ie;
  logic [CHAR_W-1:0] rx_data;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CHAR_W];

  term_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  term_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .req(bus_req), .we(bus_we), .addr(bus_addr), .acc(acc)
  );

  assign rx_data_rd = acc.rd && (acc.sel == SEL_RX_DATA);
  assign rx_ctrl_wr = acc.wr && (acc.sel == SEL_RX_CTRL);
  assign tx_ctrl_wr = acc.wr && (acc.sel == SEL_TX_CTRL);
  assign tx_data_wr = acc.wr && (acc.sel == SEL_TX_DATA);

  term_rx_side #(.CHAR_W(CHAR_W)) u_rx (
    .clk(clk), .rst_n(rst_n_sync),
    .dev_valid(kb_valid), .dev_char(kb_char),
    .data_rd(rx_data_rd), .ctrl_wr(rx_ctrl_wr), .ie_in(bus_wdata[BIT_IE]),
    .ready(rx_rdy), .ie(rx_ie), .overrun(rx_ovr), .data(rx_data)
  );

  term_tx_side #(.CHAR_W(CHAR_W)) u_tx (
    .clk(clk), .rst_n(rst_n_sync),
    .data_wr(tx_data_wr), .wr_char(bus_wdata[CHAR_W-1:0]),
    .ctrl_wr(tx_ctrl_wr), .ie_in(bus_wdata[BIT_IE]),
    .dev_done(disp_done),
    .ready(tx_rdy), .ie(tx_ie), .char_q(disp_char)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc.rd) begin
      unique case (acc.sel)
        SEL_RX_CTRL: begin
          bus_rdata[BIT_READY]   = rx_rdy;
          bus_rdata[BIT_IE]      = rx_ie;
          bus_rdata[BIT_OVERRUN] = rx_ovr;
        end
        SEL_RX_DATA: bus_rdata[CHAR_W-1:0] = rx_data;
        SEL_TX_CTRL: begin
          bus_rdata[BIT_READY] = tx_rdy;
          bus_rdata[BIT_IE]    = tx_ie;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  assign disp_valid = !tx_rdy;
  assign irq        = (rx_ie && rx_rdy) || (tx_ie && tx_rdy);
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk (
  input logic clk,
  input logic rst_n,
  input logic kb_valid,
  input logic disp_done,
  input logic rx_data_rd,
  input logic tx_data_wr,
  input logic rx_rdy,
  input logic tx_rdy,
  input logic rx_ovr,
  input logic irq
);
  p_rx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> rx_rdy);
  p_rx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_rd && !kb_valid) |=> !rx_rdy);
  p_tx_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_data_wr && tx_rdy) |=> !tx_rdy);
  p_tx_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rdy && !disp_done) |=> !tx_rdy);
  p_tx_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rdy && disp_done) |=> tx_rdy);
  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_rdy || tx_rdy));
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && rx_rdy && !rx_data_rd) |=> rx_ovr);
  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |=> rx_ovr);
endmodule

bind mmio_terminal term_mmio_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync),
  .kb_valid(kb_valid), .disp_done(disp_done),
  .rx_data_rd(rx_data_rd), .tx_data_wr(tx_data_wr),
  .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .rx_ovr(rx_ovr), .irq(irq)
);

// File: tb/test_mmio_terminal.sv
module test_mmio_terminal;
  localparam logic [31:0] A_RXC = 32'hFFFF_0000;
  localparam logic [31:0] A_RXD = 32'hFFFF_0004;
  localparam logic [31:0] A_TXC = 32'hFFFF_0008;
  localparam logic [31:0] A_TXD = 32'hFFFF_000C;
  localparam logic [31:0] A_GAP = 32'hFFFF_0010;
  localparam logic [31:0] A_OUT = 32'h0000_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_char = '0;
  logic [7:0]  disp_char;
  logic        disp_valid;
  logic        disp_done = 1'b0;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  logic       m_rx_rdy, m_rx_ie, m_ovr, m_tx_rdy, m_tx_ie;
  logic [7:0] m_rx_data, m_tx_char;

  always #4 clk = ~clk;

  mmio_terminal i_mmio_terminal (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_char(kb_char),
    .disp_char(disp_char), .disp_valid(disp_valid), .disp_done(disp_done),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [31:0] a, input logic rq, input logic we);
    if (!rq || we) return 32'h0;
    case (a)
      A_RXC:   return {29'h0, m_ovr, m_rx_ie, m_rx_rdy};
      A_RXD:   return {24'h0, m_rx_data};
      A_TXC:   return {30'h0, m_tx_ie, m_tx_rdy};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [31:0] a);
    case (a)
      A_RXC:   return "R7";
      A_RXD:   return "R2";
      A_TXC:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic cyc(input string tag, input logic [31:0] a, input logic rq, input logic we,
                     input logic [31:0] wd, input logic kv, input logic [7:0] kc, input logic dn);
    logic rd_rxd, wr_txd;
    @(negedge clk);
    bus_addr = a; bus_req = rq; bus_we = we; bus_wdata = wd;
    kb_valid = kv; kb_char = kc; disp_done = dn;
    #1;
    check(tag, bus_rdata, exp_rdata(a, rq, we));
    check("R6", {31'h0, irq}, {31'h0, (m_rx_ie && m_rx_rdy) || (m_tx_ie && m_tx_rdy)});
    check("R4", {31'h0, disp_valid}, {31'h0, !m_tx_rdy});
    if (!m_tx_rdy) check("R4", {24'h0, disp_char}, {24'h0, m_tx_char});
    @(posedge clk);
    rd_rxd = rq && !we && (a == A_RXD);
    wr_txd = rq && we && (a == A_TXD);
    if (kv) begin
      if (m_rx_rdy && !rd_rxd) m_ovr = 1'b1;
      m_rx_rdy = 1'b1; m_rx_data = kc;
    end else if (rd_rxd) m_rx_rdy = 1'b0;
    if (rq && we && a == A_RXC) m_rx_ie = wd[1];
    if (rq && we && a == A_TXC) m_tx_ie = wd[1];
    if (!m_tx_rdy) begin
      if (dn) m_tx_rdy = 1'b1;
    end else if (wr_txd) begin
      m_tx_rdy = 1'b0; m_tx_char = wd[7:0];
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int seed;
    seed = 1234;
    void'($urandom(seed));
    m_rx_rdy = 0; m_rx_ie = 0; m_ovr = 0; m_tx_rdy = 1; m_tx_ie = 0;
    m_rx_data = 0; m_tx_char = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state of both control words
    cyc("R1", A_RXC, 1, 0, 0, 0, 0, 0);
    cyc("R1", A_TXC, 1, 0, 0, 0, 0, 0);
    // R2: arrival then read back, upper bits zero
    cyc("R2", A_GAP, 0, 0, 0, 1, 8'hA5, 0);
    cyc("R2", A_RXC, 1, 0, 0, 0, 0, 0);
    cyc("R3", A_RXD, 1, 0, 0, 0, 0, 0);
    cyc("R3", A_RXC, 1, 0, 0, 0, 0, 0);
    // R3 + R7: load collides with arrival -> ready stays, no overrun
    cyc("R2", A_GAP, 0, 0, 0, 1, 8'h11, 0);
    cyc("R3", A_RXD, 1, 0, 0, 1, 8'h22, 0);
    cyc("R7", A_RXC, 1, 0, 0, 0, 0, 0);
    // R7: real overrun, sticky across reads
    cyc("R7", A_GAP, 0, 0, 0, 1, 8'h33, 0);
    cyc("R7", A_RXD, 1, 0, 0, 0, 0, 0);
    cyc("R7", A_RXC, 1, 0, 0, 0, 0, 0);
    // R4: store takes low byte, second store while busy dropped
    cyc("R4", A_TXD, 1, 1, 32'h1234_5642, 0, 0, 0);
    cyc("R4", A_TXC, 1, 0, 0, 0, 0, 0);
    cyc("R4", A_TXD, 1, 1, 32'h0000_0077, 0, 0, 0);
    // R5: store collides with done -> store dropped, ready returns
    cyc("R5", A_TXD, 1, 1, 32'h0000_0099, 0, 0, 1);
    cyc("R5", A_TXC, 1, 0, 0, 0, 0, 1);
    // R6/R8: enables; write all ones to ctrl changes only bit 1
    cyc("R8", A_TXC, 1, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R6", A_TXC, 1, 0, 0, 0, 0, 0);
    cyc("R8", A_RXC, 1, 1, 32'hFFFF_FFFE, 0, 0, 0);
    cyc("R8", A_RXC, 1, 0, 0, 0, 0, 0);
    // R9: unmapped and outside stores change nothing, reads return zero
    cyc("R9", A_GAP, 1, 1, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R9", A_OUT, 1, 1, 32'h0000_0000, 0, 0, 0);
    cyc("R9", A_GAP, 1, 0, 0, 0, 0, 0);
    cyc("R9", A_RXC, 1, 0, 0, 0, 0, 0);
    cyc("R9", A_TXC, 1, 0, 0, 0, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      logic [31:0] wd;
      case ($urandom_range(0, 5))
        0: a = A_RXC; 1: a = A_RXD; 2: a = A_TXC;
        3: a = A_TXD; 4: a = A_GAP; default: a = A_OUT;
      endcase
      wd = $urandom;
      cyc(tag_of(a), a, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, wd,
          $urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 2) == 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule